// File: doc/BRIEF.md
# Semaphore-Started Descriptor Channel Sequencer

This block is the control front of a co-processor with up to four channels. Software puts a chain of eight-word command descriptors in memory and writes a channel's command pointer. It then adds to that channel's counting semaphore. While a channel is enabled, holds a nonzero count, has a clean status and has not run off the end of its chain, the block fetches the descriptor the pointer names. It reads the words one at a time over a word-read memory port and hands the job to an external processing engine through a one-cycle start pulse and a done pulse. After the job ends, it writes a status word back into the descriptor.

Each descriptor's first control word says what happens at completion. One bit asks for the semaphore to be decremented and another asks for the channel's flag in the global status to be set. The interrupt line is the OR of those flags. A nonzero link word moves the channel on to the next descriptor. A zero link parks the channel until software writes its command pointer again. Fetch and engine errors record a code in the channel status. A nonzero status keeps the channel halted until software clears it. Channels share one engine and are served one descriptor at a time, lowest index first.

Top module: `desc_chan_ctrl`

## Requirements
- R1: After reset the global status, enable mask, every command pointer, semaphore and channel status read as zero, `irq` is low, and neither `mem_req` nor `eng_start` is asserted.
- R2: Register map (byte offsets): global status at 0x010, global status clear at 0x018, enable mask at 0x020. Channel n's registers sit at 0x100 + 0x40·n: command pointer at +0x00 (read/write), semaphore at +0x10, status at +0x20, status clear at +0x28. The enable mask keeps only bits for implemented channels (0..NCH-1), and the other bits read back as zero.
- R3: A write to a semaphore register adds the low SW bits of the written value to the count. A read returns the count.
- R4: A channel starts a fetch only when its enable bit is set, its semaphore is nonzero, its status is zero and it is not parked. A disabled channel with a nonzero count issues no memory request and starts no job.
- R5: A descriptor is read from the captured pointer p at p+0x00, p+0x04 … p+0x18 in increasing order. Each request holds its address stable until `mem_ack`. Word order: link, control0, control1, source, destination, size, payload, status (status at p+0x1C is not read).
- R6: After the seventh word arrives, `eng_start` pulses for one cycle with `eng_chan`, `eng_src`, `eng_dst`, `eng_size`, `eng_payload` and `eng_cfg` (control1) taken from the descriptor. `eng_mode[6:0]` carries control0 bits {13,12,11,9,8,6,5}: hash terminate, hash init, payload-is-key, cipher init, encrypt, hash enable, cipher enable.
- R7: After `eng_done`, the block writes the job's error code (zero when clean) to p+0x1C.
- R8: At completion, control0 bit 1 decrements the channel's semaphore (never below zero). Control0 bit 0 sets bit n of the global status. `irq` is high exactly while any global status bit is set.
- R9: At completion, a nonzero link word replaces the command pointer and the channel carries on while its count is nonzero. A zero link leaves the pointer and parks the channel, and a command pointer write unparks it.
- R10: Writing ones to the global clear address clears the matching flag bits. Writing ones to a channel status clear address clears the matching status bits. A cleared channel with a nonzero count resumes.
- R11: A fetch that returns `mem_err` sets channel status code 0x01 and sets the channel's global flag regardless of control bits. It starts no job, leaves the semaphore unchanged and halts the channel.
- R12: An engine error reported with `eng_done` sets status code 0x02, a write-back error adds 0x04, and the channel halts. The completion actions of R8 still follow control0.
- R13: With several channels ready, the lowest-indexed one is served first, and only one descriptor is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | OR of the global status flags |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Write data (status word) |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Request failed, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| eng_start | output | 1 | One-cycle job start |
| eng_chan | output | $clog2(NCH) | Channel owning the job |
| eng_mode | output | 7 | Mode bits from control0 |
| eng_cfg | output | 32 | Control1 word |
| eng_src | output | 32 | Source address |
| eng_dst | output | 32 | Destination address |
| eng_size | output | 32 | Byte count |
| eng_payload | output | 32 | Payload address |
| eng_done | input | 1 | Job finished |
| eng_err | input | 1 | Job failed, valid with `eng_done` |

## Verification
A corrupted semaphore or park flag shows up within one descriptor time, about 25 cycles. Either an extra job appears on the engine port or an expected one never comes, and the semaphore read-back is off by the decrement that should or should not have happened. A wrong word index or pointer shows in the fetch address sequence and in the job fields on the very start pulse. A wrong completion decode shows in the write-back word, the global flags and `irq` as soon as the write-back is acknowledged. Sweeping every channel against every combination of the two completion bits makes each such fault visible on the ports of the affected channel.

// File: rtl/desc_chan_ctrl.sv
module desc_chan_ctrl #(
  parameter int NCH    = 4,
  parameter int AW     = 32,
  parameter int SW     = 8,
  parameter int ADDR_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic                     irq,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [31:0]              mem_wdata,
  input  logic                     mem_ack,
  input  logic                     mem_err,
  input  logic [31:0]              mem_rdata,
  output logic                     eng_start,
  output logic [$clog2(NCH)-1:0]   eng_chan,
  output logic [6:0]               eng_mode,
  output logic [31:0]              eng_cfg,
  output logic [31:0]              eng_src,
  output logic [31:0]              eng_dst,
  output logic [31:0]              eng_size,
  output logic [31:0]              eng_payload,
  input  logic                     eng_done,
  input  logic                     eng_err
);
  localparam int CW    = $clog2(NCH);
  localparam int NWORD = 7;
  localparam logic [7:0] E_FETCH = 8'h01;
  localparam logic [7:0] E_ENG   = 8'h02;
  localparam logic [7:0] E_WB    = 8'h04;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_START, S_WAIT, S_WB} st_t;

  st_t              state;
  logic [AW-1:0]    cmdptr [NCH];
  logic [SW-1:0]    sema   [NCH];
  logic [7:0]       cstat  [NCH];
  logic [NCH-1:0]   en, gstat, park;
  logic [CW-1:0]    act;
  logic [AW-1:0]    cur;
  logic [2:0]       widx;
  logic [31:0]      dw [NWORD];
  logic [7:0]       code;

  logic [NCH-1:0]   rdy, w_ptr, w_sem, w_clr, dec, gset;
  logic [7:0]       cset [NCH];
  logic [CW-1:0]    pick;
  logic             any, fin, ferr, g_clr, g_en, glob, in_ch;
  logic [1:0]       rch;
  logic [5:0]       roff;
  logic [7:0]       fin_code;

  assign glob  = reg_addr[ADDR_W-1:8] == '0;
  assign rch   = reg_addr[7:6];
  assign roff  = reg_addr[5:0];
  assign in_ch = (reg_addr[ADDR_W-1:8] == (ADDR_W-8)'(1)) && (32'(rch) < NCH);
  assign g_clr = reg_we && glob && reg_addr[7:0] == 8'h18;
  assign g_en  = reg_we && glob && reg_addr[7:0] == 8'h20;

  assign fin      = (state == S_WB) && mem_ack;
  assign ferr     = (state == S_FETCH) && mem_ack && mem_err;
  assign fin_code = code | (mem_err ? E_WB : 8'h00);

  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      rdy[i] = en[i] && (sema[i] != '0) && (cstat[i] == 8'h00) && !park[i];
      if (rdy[i]) begin
        any  = 1'b1;
        pick = CW'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      w_ptr[i] = reg_we && in_ch && (32'(rch) == i) && roff == 6'h00;
      w_sem[i] = reg_we && in_ch && (32'(rch) == i) && roff == 6'h10;
      w_clr[i] = reg_we && in_ch && (32'(rch) == i) && roff == 6'h28;
      dec[i]   = fin && (act == CW'(i)) && dw[1][1] && (sema[i] != '0);
      gset[i]  = (act == CW'(i)) && (ferr || (fin && dw[1][0]));
      cset[i]  = (ferr && act == CW'(i)) ? E_FETCH :
                 (fin && act == CW'(i))  ? fin_code : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      act   <= '0;
      cur   <= '0;
      widx  <= '0;
      code  <= '0;
      en    <= '0;
      gstat <= '0;
      park  <= '0;
      for (int i = 0; i < NCH; i++) begin
        cmdptr[i] <= '0;
        sema[i]   <= '0;
        cstat[i]  <= '0;
      end
      for (int w = 0; w < NWORD; w++) dw[w] <= '0;
    end else begin
      case (state)
        S_IDLE: if (any) begin
          act   <= pick;
          cur   <= cmdptr[pick];
          widx  <= '0;
          state <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) state <= S_IDLE;
          else begin
            dw[widx] <= mem_rdata;
            if (widx == 3'(NWORD - 1)) state <= S_START;
            else widx <= widx + 3'd1;
          end
        end
        S_START: state <= S_WAIT;
        S_WAIT: if (eng_done) begin
          code  <= eng_err ? E_ENG : 8'h00;
          state <= S_WB;
        end
        S_WB: if (mem_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase

      if (g_en) en <= reg_wdata[NCH-1:0];
      gstat <= (gstat & ~(g_clr ? reg_wdata[NCH-1:0] : '0)) | gset;

      for (int i = 0; i < NCH; i++) begin
        if (w_ptr[i]) begin
          cmdptr[i] <= reg_wdata[AW-1:0];
          park[i]   <= 1'b0;
        end else if (fin && act == CW'(i)) begin
          if (dw[0][AW-1:0] != '0) cmdptr[i] <= dw[0][AW-1:0];
          else park[i] <= 1'b1;
        end
        sema[i]  <= sema[i] + (w_sem[i] ? reg_wdata[SW-1:0] : '0) - SW'(dec[i]);
        cstat[i] <= (cstat[i] & ~(w_clr[i] ? reg_wdata[7:0] : 8'h00)) | cset[i];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (glob) begin
      case (reg_addr[7:0])
        8'h10:   reg_rdata = 32'(gstat);
        8'h20:   reg_rdata = 32'(en);
        default: reg_rdata = '0;
      endcase
    end else if (in_ch) begin
      case (roff)
        6'h00:   reg_rdata = 32'(cmdptr[rch]);
        6'h10:   reg_rdata = 32'(sema[rch]);
        6'h20:   reg_rdata = 32'(cstat[rch]);
        default: reg_rdata = '0;
      endcase
    end
  end

  assign irq         = |gstat;
  assign mem_req     = (state == S_FETCH) || (state == S_WB);
  assign mem_we      = (state == S_WB);
  assign mem_addr    = cur + ((state == S_WB) ? AW'(28) : AW'({widx, 2'b00}));
  assign mem_wdata   = 32'(code);
  assign eng_start   = (state == S_START);
  assign eng_chan    = act;
  assign eng_mode    = {dw[1][13], dw[1][12], dw[1][11], dw[1][9], dw[1][8], dw[1][6], dw[1][5]};
  assign eng_cfg     = dw[2];
  assign eng_src     = dw[3];
  assign eng_dst     = dw[4];
  assign eng_size    = dw[5];
  assign eng_payload = dw[6];

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(state) == S_FETCH || $past(state) == S_WB));

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(g_clr));

  assert_one_job_R13: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !mem_req);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_sema_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !w_sem[g] |=> (sema[g] == $past(sema[g]) || sema[g] == $past(sema[g]) - SW'(1)));
  end
endmodule

// File: tb/desc_chan_ctrl_tb.sv
module desc_chan_ctrl_tb;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        reg_we = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        irq, mem_req, mem_we, mem_ack = 0, mem_err = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic        eng_start, eng_done = 0, eng_err = 0;
  logic [1:0]  eng_chan;
  logic [6:0]  eng_mode;
  logic [31:0] eng_cfg, eng_src, eng_dst, eng_size, eng_payload;

  desc_chan_ctrl u_dut (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .irq,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_err, .mem_rdata,
    .eng_start, .eng_chan, .eng_mode, .eng_cfg, .eng_src, .eng_dst, .eng_size,
    .eng_payload, .eng_done, .eng_err);

  logic [31:0] mem [0:511];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic        err_inj = 0;
  int          nerr = 0, nchk = 0, njob = 0, nf = 0, ecnt = 0;
  logic [1:0]  jch [0:63];
  logic [31:0] jsrc [0:63];
  logic [6:0]  jmode [0:63];
  logic [31:0] fa [0:1023];
  bit          done = 0;
  int          esema [4];

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_err   <= (mem_addr == err_addr);
      mem_rdata <= mem[mem_addr[10:2]];
      if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
      else begin
        fa[nf] <= mem_addr;
        nf     <= nf + 1;
      end
    end
  end

  always @(posedge clk) begin
    eng_done <= 1'b0;
    eng_err  <= 1'b0;
    if (ecnt != 0) begin
      ecnt <= ecnt - 1;
      if (ecnt == 1) begin
        eng_done <= 1'b1;
        eng_err  <= err_inj;
      end
    end
    if (eng_start) begin
      ecnt        <= 3;
      jch[njob]   <= eng_chan;
      jsrc[njob]  <= eng_src;
      jmode[njob] <= eng_mode;
      njob        <= njob + 1;
    end
  end

  function automatic logic [11:0] ca(int c, int off);
    return 12'(32'h100 + 32'h40 * c + off);
  endfunction

  function automatic logic [6:0] emode(logic [31:0] c0);
    return {c0[13], c0[12], c0[11], c0[9], c0[8], c0[6], c0[5]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(int p, logic [31:0] nxt, logic [31:0] c0, logic [31:0] src);
    mem[p/4 + 0] = nxt;
    mem[p/4 + 1] = c0;
    mem[p/4 + 2] = 32'h0002_0010;
    mem[p/4 + 3] = src;
    mem[p/4 + 4] = src + 32'h100;
    mem[p/4 + 5] = 32'd16;
    mem[p/4 + 6] = src ^ 32'hA5;
    mem[p/4 + 7] = 32'hDEAD_BEEF;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int j0, f0, p, pa, pb;
    logic [31:0] c0;
    for (int i = 0; i < 512; i++) mem[i] = 0;
    for (int i = 0; i < 4; i++) esema[i] = 0;
    idle(3);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 eng_start", 32'(eng_start), 0);
    rst_n = 1;
    idle(2);
    rd(12'h010, d); check("R1 gstat", d, 0);
    rd(12'h020, d); check("R1 enable", d, 0);
    for (int c = 0; c < 4; c++) begin
      rd(ca(c, 0), d);    check("R1 cmdptr", d, 0);
      rd(ca(c, 'h10), d); check("R1 sema", d, 0);
      rd(ca(c, 'h20), d); check("R1 cstat", d, 0);
    end
    check("R1 irq", 32'(irq), 0);

    wr(ca(0, 'h10), 3); rd(ca(0, 'h10), d); check("R3 sema add", d, 3);
    wr(ca(0, 'h10), 2); rd(ca(0, 'h10), d); check("R3 sema add twice", d, 5);
    esema[0] = 5;
    idle(20);
    check("R4 disabled no fetch", 32'(nf), 0);

    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 4; k++) begin
        int idx;
        idx = c * 4 + k;
        p   = 32'h20 * (idx + 1);
        c0  = 32'(k) | ((idx % 2 == 1) ? 32'h3960 : 32'h0220);
        put_desc(p, 0, c0, 32'h1000 + idx);
        j0 = njob; f0 = nf;
        wr(ca(c, 0), p);
        wr(12'h020, 32'(1) << c);
        wr(ca(c, 'h10), 2);
        esema[c] += 2;
        idle(60);
        check("R9 parked after one job", 32'(njob), 32'(j0 + 1));
        check("R4 channel", 32'(jch[j0]), 32'(c));
        check("R6 source", jsrc[j0], 32'h1000 + idx);
        check("R6 mode bits", 32'(jmode[j0]), 32'(emode(c0)));
        check("R7 writeback", mem[p/4 + 7], 0);
        if (k[1]) esema[c] -= 1;
        rd(ca(c, 'h10), d); check("R8 sema decrement", d, 32'(esema[c]));
        rd(12'h010, d); check("R8 global flag", d, k[0] ? (32'(1) << c) : 0);
        check("R8 irq", 32'(irq), 32'(k[0]));
        if (idx == 0) begin
          check("R5 fetch count", 32'(nf - f0), 7);
          for (int w = 0; w < 7; w++) check("R5 fetch address", fa[f0 + w], p + 4 * w);
        end
        wr(12'h018, 32'hF);
        rd(12'h010, d); check("R10 global clear", d, 0);
        check("R10 irq low", 32'(irq), 0);
        wr(12'h020, 0);
      end
    end

    wr(12'h020, 32'hFF); rd(12'h020, d); check("R2 enable mask width", d, 32'hF);
    idle(30);
    wr(12'h020, 0);
    wr(ca(2, 0), 32'h1234_5678); rd(ca(2, 0), d); check("R2 cmdptr readback", d, 32'h1234_5678);

    pa = 32'h300; pb = 32'h340;
    put_desc(pa, pb, 3, 32'h2000);
    put_desc(pb, 0, 3, 32'h2001);
    j0 = njob;
    wr(ca(1, 0), pa);
    wr(ca(1, 'h10), 2); esema[1] += 2;
    wr(12'h020, 32'h2);
    idle(120);
    check("R9 chain job count", 32'(njob), 32'(j0 + 2));
    check("R9 chain first", jsrc[j0], 32'h2000);
    check("R9 chain second", jsrc[j0 + 1], 32'h2001);
    esema[1] -= 2;
    rd(ca(1, 'h10), d); check("R9 chain sema", d, 32'(esema[1]));
    rd(ca(1, 0), d); check("R9 pointer follows link", d, pb);
    check("R7 chain writeback", mem[pa/4 + 7], 0);
    wr(12'h018, 32'hF); wr(12'h020, 0);

    put_desc(32'h380, 0, 2, 32'h3003);
    put_desc(32'h3A0, 0, 2, 32'h3000);
    j0 = njob;
    wr(ca(3, 0), 32'h380);
    wr(ca(0, 0), 32'h3A0);
    wr(ca(2, 0), 32'h3A0);
    wr(12'h020, 32'h9);
    idle(120);
    check("R13 two jobs", 32'(njob), 32'(j0 + 2));
    check("R13 low index first", 32'(jch[j0]), 0);
    check("R13 then high index", 32'(jch[j0 + 1]), 3);
    esema[0] -= 1; esema[3] -= 1;
    check("R4 disabled channel idle", 32'(njob), 32'(j0 + 2));
    wr(12'h020, 32'h4);
    idle(60);
    check("R4 enabled channel runs", 32'(jch[j0 + 2]), 2);
    esema[2] -= 1;
    wr(12'h020, 0);

    p = 32'h3C0;
    put_desc(p, 0, 3, 32'h4000);
    err_addr = p + 4;
    j0 = njob;
    wr(ca(2, 0), p);
    wr(12'h020, 32'h4);
    idle(60);
    rd(ca(2, 'h20), d); check("R11 fetch error code", d, 1);
    rd(12'h010, d); check("R11 flag raised", d, 32'h4);
    check("R11 no job", 32'(njob), 32'(j0));
    rd(ca(2, 'h10), d); check("R11 sema kept", d, 32'(esema[2]));
    err_addr = 32'hFFFF_FFFF;
    idle(30);
    check("R11 halted", 32'(njob), 32'(j0));
    wr(ca(2, 'h28), 1);
    idle(60);
    rd(ca(2, 'h20), d); check("R10 status clear", d, 0);
    check("R10 resume after clear", 32'(njob), 32'(j0 + 1));
    esema[2] -= 1;
    rd(ca(2, 'h10), d); check("R8 sema after resume", d, 32'(esema[2]));
    wr(12'h018, 32'hF); wr(12'h020, 0);

    p = 32'h3E0;
    put_desc(p, 0, 2, 32'h5000);
    err_inj = 1;
    wr(ca(3, 0), p);
    wr(12'h020, 32'h8);
    idle(60);
    err_inj = 0;
    rd(ca(3, 'h20), d); check("R12 engine error code", d, 2);
    check("R12 writeback code", mem[p/4 + 7], 2);
    rd(12'h010, d); check("R12 no flag without bit0", d, 0);
    esema[3] -= 1;
    rd(ca(3, 'h10), d); check("R12 sema decrement", d, 32'(esema[3]));

    done = 1;
    summary();
    $finish;
  end
endmodule